// File: doc/BRIEF.md
# Cascaded Maskable Interrupt Controller

This block gathers fifteen device interrupt request lines and one non-maskable request and presents them to a processor as two request outputs plus a vector handshake. Internally it is built from two identical eight-input controller units. The secondary unit collects the upper eight device lines. Its combined request feeds input 2 of the primary unit. The primary unit's combined request drives the processor's maskable request output. Input 2 of the primary is therefore a cascade slot and carries no device line of its own.

Each unit turns a rising edge on a device line into a pending bit. Each unit also holds an eight-bit mask register, where a 1 blocks that input. A masked request is not lost: it stays pending and is delivered as soon as its mask bit is cleared. Software reads and writes the two mask registers, and reads the two status (pending) registers, through a small address/write-enable/data port.

The processor claims an interrupt by pulsing `ack_stb`. A two-state sequencer (`ST_IDLE`, `ST_ANSWER`) accepts the strobe in `ST_IDLE`, picks the winning source, clears it, and moves to `ST_ANSWER` for exactly one cycle. In that cycle it presents the vector and the valid flag, then always returns to `ST_IDLE`. The non-maskable source wins over every maskable one and answers with vector 0x02. Primary input n answers with 0x20+n, and secondary input n answers with 0x28+n.

Top module: `casc_irq_ctrl`

## Requirements
- R1: After reset, both mask registers read 0xFF (all inputs blocked), both status registers read 0x00, and `irq_out`, `nmi_out` and `vec_valid` are low.
- R2: A low-to-high transition on a device line, seen at a clock edge, sets that input's pending bit, which shows in the status register from the next cycle. A line that stays high after its request was acknowledged does not set the bit again.
- R3: A request on a masked input stays pending while masked. `irq_out` goes high in the cycle after a register write clears its mask bit.
- R4: `irq_out` is high exactly when some primary input is both pending and unmasked. The cascade slot (primary input 2) counts as pending while any secondary input is pending and unmasked, so primary mask bit 2 blocks all secondary lines.
- R5: When `ack_stb` is sampled high in `ST_IDLE` and a source is deliverable, the next cycle shows `vec_valid`=1 with vector 0x20+n for primary input n, or 0x28+n for secondary input n. The winner's pending bit is cleared at the same edge.
- R6: Maskable sources are ranked by fixed priority: primary inputs 0 and 1, then the cascade slot (secondary inputs 0 to 7, lowest first), then primary inputs 3 to 7.
- R7: A rising edge on `nmi_req` sets `nmi_out`, whatever the masks hold. An acknowledge taken while `nmi_out` is high answers vector 0x02 ahead of every maskable source and drops `nmi_out`.
- R8: An acknowledge taken when nothing is deliverable answers with `vec_valid`=0 and `vec_out`=0, and leaves every pending bit unchanged.
- R9: The sequencer stays in `ST_ANSWER` for one cycle only. An `ack_stb` seen in `ST_ANSWER` is ignored, and no source is cleared.
- R10: Register addresses are 0 = primary mask, 1 = primary status, 2 = secondary mask, 3 = secondary status. Bit n of a register is input n. Primary status bit 2 shows the live cascade request. Writes to a status address change nothing.
- R11: If a new rising edge reaches an input at the same edge that its acknowledge clears it, the pending bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_req | input | 15 | Device lines: [1:0] to primary inputs 1:0, [6:2] to primary inputs 7:3, [14:7] to secondary inputs 7:0 |
| nmi_req | input | 1 | Non-maskable request, edge latched |
| irq_out | output | 1 | Maskable request to the processor |
| nmi_out | output | 1 | Non-maskable request to the processor |
| ack_stb | input | 1 | Acknowledge strobe from the processor |
| vec_valid | output | 1 | Vector response valid, one cycle after an accepted strobe |
| vec_out | output | 8 | Vector number (0 when not valid) |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on `reg_addr`) |

## Verification
The bench goes after the cascade corner cases. It masks primary slot 2 while a secondary line is pending. A design that ignored that bit would raise `irq_out` early. A design that ranked the secondary lines after primary 7 would hand out 0x25 before 0x29. The bench also sends a strobe on the cycle straight after an accepted one, and a fresh edge on the very line being cleared. A wrong design would, respectively, drop a second pending request or lose a real interrupt. Finally, a device line is held high across its acknowledge, which catches level latching that would re-raise the request without end.

// File: rtl/casc_irq_pkg.sv
package casc_irq_pkg;

    localparam int UNIT_LINES = 8;
    localparam int IDX_W      = $clog2(UNIT_LINES);
    localparam int CASC_SLOT  = 2;
    localparam int DEV_LINES  = 2 * UNIT_LINES - 1;
    localparam int VEC_W      = 8;

    localparam logic [VEC_W-1:0] VEC_BASE = 8'h20;
    localparam logic [VEC_W-1:0] VEC_SEC  = VEC_BASE + VEC_W'(UNIT_LINES);
    localparam logic [VEC_W-1:0] VEC_NMI  = 8'h02;

    localparam logic [1:0] RA_PRI_MASK = 2'd0;
    localparam logic [1:0] RA_PRI_STAT = 2'd1;
    localparam logic [1:0] RA_SEC_MASK = 2'd2;
    localparam logic [1:0] RA_SEC_STAT = 2'd3;

    typedef enum logic {
        ST_IDLE,
        ST_ANSWER
    } ack_state_e;

endpackage

// File: rtl/irq_unit.sv
module irq_unit
    import casc_irq_pkg::*;
#(
    parameter int                LINES    = UNIT_LINES,
    parameter logic [LINES-1:0]  LEVEL_IN = '0,
    localparam int               IW       = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] req,
    input  logic             mask_we,
    input  logic [LINES-1:0] mask_wd,
    input  logic             clr_en,
    input  logic [IW-1:0]    clr_idx,
    output logic [LINES-1:0] pend,
    output logic [LINES-1:0] mask,
    output logic             int_out,
    output logic             hit,
    output logic [IW-1:0]    idx
);

    logic [LINES-1:0] avail;

    // Mask register: blocks everything out of reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '1;
        end else if (mask_we) begin
            mask <= mask_wd;
        end
    end

    // Per-input capture: level pass-through for a cascade slot, edge latch otherwise
    for (genvar b = 0; b < LINES; b++) begin : g_line
        if (LEVEL_IN[b]) begin : g_level
            assign pend[b] = req[b];
        end else begin : g_edge
            logic prev_q;
            logic pend_q;
            logic clr_me;
            assign clr_me = clr_en && (clr_idx == IW'(b));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prev_q <= 1'b0;
                    pend_q <= 1'b0;
                end else begin
                    prev_q <= req[b];
                    pend_q <= (pend_q && !clr_me) || (req[b] && !prev_q);
                end
            end
            assign pend[b] = pend_q;
        end
    end

    assign avail   = pend & ~mask;
    assign int_out = |avail;

    // Fixed priority: lowest index wins (scan high to low, last write stands)
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (avail[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
    import casc_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_stb,
    input  logic             nmi_pend,
    input  logic             p_hit,
    input  logic [IDX_W-1:0] p_idx,
    input  logic             s_hit,
    input  logic [IDX_W-1:0] s_idx,
    output logic             nmi_clr,
    output logic             p_clr,
    output logic             s_clr,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_out
);

    ack_state_e state_q, state_d;
    logic       take;
    logic       pick_casc;
    logic       pick_pri;
    logic [VEC_W-1:0] vec_d;
    logic       valid_d;

    assign take      = (state_q == ST_IDLE) && ack_stb;
    assign pick_casc = !nmi_pend && p_hit && (p_idx == IDX_W'(CASC_SLOT)) && s_hit;
    assign pick_pri  = !nmi_pend && p_hit && (p_idx != IDX_W'(CASC_SLOT));

    assign nmi_clr = take && nmi_pend;
    assign p_clr   = take && pick_pri;
    assign s_clr   = take && pick_casc;

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = ack_stb ? ST_ANSWER : ST_IDLE;
            ST_ANSWER: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        valid_d = 1'b0;
        vec_d   = '0;
        if (nmi_pend) begin
            valid_d = 1'b1;
            vec_d   = VEC_NMI;
        end else if (pick_casc) begin
            valid_d = 1'b1;
            vec_d   = VEC_SEC + VEC_W'(s_idx);
        end else if (pick_pri) begin
            valid_d = 1'b1;
            vec_d   = VEC_BASE + VEC_W'(p_idx);
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: the response lives for the ST_ANSWER cycle only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end else if (take) begin
            vec_valid <= valid_d;
            vec_out   <= vec_d;
        end else begin
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end
    end

endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
    import casc_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DEV_LINES-1:0] dev_req,
    input  logic                 nmi_req,
    output logic                 irq_out,
    output logic                 nmi_out,
    input  logic                 ack_stb,
    output logic                 vec_valid,
    output logic [VEC_W-1:0]     vec_out,
    input  logic [1:0]           reg_addr,
    input  logic                 reg_we,
    input  logic [UNIT_LINES-1:0] reg_wdata,
    output logic [UNIT_LINES-1:0] reg_rdata
);

    localparam logic [UNIT_LINES-1:0] PRI_LEVEL = UNIT_LINES'(1) << CASC_SLOT;

    logic [UNIT_LINES-1:0] p_req, s_req;
    logic [UNIT_LINES-1:0] p_pend, s_pend, p_mask, s_mask;
    logic                  p_int, s_int, p_hit, s_hit;
    logic [IDX_W-1:0]      p_idx, s_idx;
    logic                  p_clr, s_clr, nmi_clr;
    logic                  nmi_prev, nmi_pend;

    assign s_req = dev_req[DEV_LINES-1:UNIT_LINES-1];
    assign p_req = {dev_req[UNIT_LINES-2:CASC_SLOT], s_int, dev_req[CASC_SLOT-1:0]};

    irq_unit #(.LINES(UNIT_LINES), .LEVEL_IN('0)) u_sec (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (s_req),
        .mask_we (reg_we && (reg_addr == RA_SEC_MASK)),
        .mask_wd (reg_wdata),
        .clr_en  (s_clr),
        .clr_idx (s_idx),
        .pend    (s_pend),
        .mask    (s_mask),
        .int_out (s_int),
        .hit     (s_hit),
        .idx     (s_idx)
    );

    irq_unit #(.LINES(UNIT_LINES), .LEVEL_IN(PRI_LEVEL)) u_pri (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (p_req),
        .mask_we (reg_we && (reg_addr == RA_PRI_MASK)),
        .mask_wd (reg_wdata),
        .clr_en  (p_clr),
        .clr_idx (p_idx),
        .pend    (p_pend),
        .mask    (p_mask),
        .int_out (p_int),
        .hit     (p_hit),
        .idx     (p_idx)
    );

    // Non-maskable source: edge latched, never gated
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_prev <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_prev <= nmi_req;
            nmi_pend <= (nmi_pend && !nmi_clr) || (nmi_req && !nmi_prev);
        end
    end

    irq_ack_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_stb   (ack_stb),
        .nmi_pend  (nmi_pend),
        .p_hit     (p_hit),
        .p_idx     (p_idx),
        .s_hit     (s_hit),
        .s_idx     (s_idx),
        .nmi_clr   (nmi_clr),
        .p_clr     (p_clr),
        .s_clr     (s_clr),
        .vec_valid (vec_valid),
        .vec_out   (vec_out)
    );

    assign irq_out = p_int;
    assign nmi_out = nmi_pend;

    always_comb begin
        unique case (reg_addr)
            RA_PRI_MASK: reg_rdata = p_mask;
            RA_PRI_STAT: reg_rdata = p_pend;
            RA_SEC_MASK: reg_rdata = s_mask;
            default:     reg_rdata = s_pend;
        endcase
    end

endmodule

// File: rtl/casc_irq_chk.sv
module casc_irq_chk
    import casc_irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ack_stb,
    input logic             nmi_out,
    input logic             vec_valid,
    input logic [VEC_W-1:0] vec_out
);

    // R9: the answer lasts a single cycle
    p_answer_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    // R5: a response is always preceded by a strobe
    p_valid_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(ack_stb));

    // R7: a pending non-maskable request wins the acknowledge
    p_nmi_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && $past(nmi_out)) |-> (vec_out == VEC_NMI));

    // R7: the non-maskable output only drops through its own answer
    p_nmi_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nmi_out) |-> (vec_valid && vec_out == VEC_NMI));

    // R6: vectors stay in the device range and never name the cascade slot
    p_vec_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ((vec_out == VEC_NMI) ||
                       (vec_out[7:4] == 4'h2 && vec_out[3:0] != 4'(CASC_SLOT))));

endmodule

bind casc_irq_ctrl casc_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_stb   (ack_stb),
    .nmi_out   (nmi_out),
    .vec_valid (vec_valid),
    .vec_out   (vec_out)
);

// File: tb/casc_irq_ctrl_tb_top.sv
module casc_irq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [14:0] dev_req;
    logic        nmi_req;
    logic        irq_out, nmi_out, ack_stb, vec_valid;
    logic [7:0]  vec_out;
    logic [1:0]  reg_addr;
    logic        reg_we;
    logic [7:0]  reg_wdata, reg_rdata;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    casc_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .nmi_req(nmi_req),
        .irq_out(irq_out), .nmi_out(nmi_out), .ack_stb(ack_stb),
        .vec_valid(vec_valid), .vec_out(vec_out), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // line numbers 0..15; line 2 is the cascade slot (no device)
    logic [15:0] m_pend, m_prev;
    logic [7:0]  m_pm, m_sm, m_vec;
    logic        m_nmi, m_nprev, m_busy, m_vv;
    int ord [15] = '{0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7};

    function automatic int line_of(int k);
        return (k < 2) ? k : k + 1;
    endfunction

    function automatic bit masked(int l);
        if (l < 8) return m_pm[l];
        return m_pm[2] | m_sm[l-8];
    endfunction

    function automatic bit m_casc();
        for (int l = 8; l < 16; l++) if (m_pend[l] && !m_sm[l-8]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit m_irq();
        for (int j = 0; j < 15; j++) if (m_pend[ord[j]] && !masked(ord[j])) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [7:0] m_rd(logic [1:0] a);
        case (a)
            2'd0: return m_pm;
            2'd1: return {m_pend[7:3], m_casc(), m_pend[1:0]};
            2'd2: return m_sm;
            default: return m_pend[15:8];
        endcase
    endfunction

    always @(posedge clk) begin
        int win;
        win = -1;
        if (!rst_n) begin
            m_pend = '0; m_prev = '0; m_nmi = 0; m_nprev = 0;
            m_busy = 0; m_vv = 0; m_vec = 0; m_pm = 8'hFF; m_sm = 8'hFF;
        end else begin
            if (!m_busy && ack_stb) begin
                if (m_nmi) win = 100;
                else for (int j = 0; j < 15; j++)
                    if (win < 0 && m_pend[ord[j]] && !masked(ord[j])) win = ord[j];
                m_busy = 1;
                m_vv   = (win >= 0);
                m_vec  = (win == 100) ? 8'h02 : (win >= 0 ? 8'h20 + 8'(win) : 8'h00);
                if (win == 100) m_nmi = 0;
                else if (win >= 0) m_pend[win] = 0;
            end else begin
                m_busy = 0; m_vv = 0; m_vec = 0;
            end
            for (int k = 0; k < 15; k++) begin
                if (dev_req[k] && !m_prev[line_of(k)]) m_pend[line_of(k)] = 1;
                m_prev[line_of(k)] = dev_req[k];
            end
            if (nmi_req && !m_nprev) m_nmi = 1;
            m_nprev = nmi_req;
            if (reg_we && reg_addr == 2'd0) m_pm = reg_wdata;
            if (reg_we && reg_addr == 2'd2) m_sm = reg_wdata;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 irq_out vs model", irq_out, m_irq());
            chk("R7 nmi_out vs model", nmi_out, m_nmi);
            chk("R5 vec_valid vs model", vec_valid, m_vv);
            chk("R6 vec_out vs model", vec_out, m_vec);
            chk("R10 reg_rdata vs model", reg_rdata, m_rd(reg_addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic pulse(int k);
        dev_req[k] = 1'b1; tick(); dev_req[k] = 1'b0; tick();
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1; tick(); reg_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] v);
        reg_addr = a; @(negedge clk); v = reg_rdata; tick();
    endtask

    task automatic ack(output logic v, output logic [7:0] vec);
        ack_stb = 1'b1; tick(); ack_stb = 1'b0; v = vec_valid; vec = vec_out; tick();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] r, vc;
        logic       v;
        rst_n = 0; dev_req = '0; nmi_req = 0; ack_stb = 0;
        reg_addr = 0; reg_we = 0; reg_wdata = 0;
        repeat (3) tick();
        rst_n = 1; tick();

        // R1 reset state
        chk("R1 irq_out", irq_out, 0);
        chk("R1 nmi_out", nmi_out, 0);
        chk("R1 vec_valid", vec_valid, 0);
        rd(2'd0, r); chk("R1 primary mask", r, 8'hFF);
        rd(2'd2, r); chk("R1 secondary mask", r, 8'hFF);
        rd(2'd1, r); chk("R1 primary status", r, 8'h00);
        rd(2'd3, r); chk("R1 secondary status", r, 8'h00);

        // R2 / R3: request on masked line 4 is held
        pulse(3);
        rd(2'd1, r); chk("R2 edge latched line4", r, 8'h10);
        chk("R3 masked no irq", irq_out, 0);
        wr(2'd0, 8'h00);
        chk("R3 irq after unmask", irq_out, 1);
        ack(v, vc);
        chk("R5 valid", v, 1); chk("R5 vector line4", vc, 8'h24);
        rd(2'd1, r); chk("R5 pending cleared", r, 8'h00);

        // R2: held level does not re-latch
        dev_req[0] = 1'b1; tick(); tick();
        ack(v, vc); chk("R2 vector line0", vc, 8'h20);
        tick(); tick();
        rd(2'd1, r); chk("R2 no relatch on level", r, 8'h00);
        dev_req[0] = 1'b0; tick();

        // R6 priority incl. cascade slot
        pulse(4); pulse(8); pulse(1);
        wr(2'd2, 8'h00);
        ack(v, vc); chk("R6 first line1", vc, 8'h21);
        ack(v, vc); chk("R6 second secondary1", vc, 8'h29);
        ack(v, vc); chk("R6 third line5", vc, 8'h25);
        ack(v, vc); chk("R8 empty valid", v, 0); chk("R8 empty vec", vc, 8'h00);

        // R4 primary slot 2 masks all secondary lines
        pulse(11);
        rd(2'd3, r); chk("R4 secondary pending", r, 8'h10);
        wr(2'd0, 8'h04);
        chk("R4 cascade masked", irq_out, 0);
        rd(2'd1, r); chk("R10 live cascade bit", r, 8'h04);
        wr(2'd0, 8'h00);
        chk("R4 cascade unmasked", irq_out, 1);
        ack(v, vc); chk("R5 secondary vector", vc, 8'h2C);
        rd(2'd3, r); chk("R5 secondary cleared", r, 8'h00);

        // R7 non-maskable source
        wr(2'd0, 8'hFF);
        pulse(0);
        nmi_req = 1; tick(); nmi_req = 0; tick();
        chk("R7 nmi_out despite masks", nmi_out, 1);
        chk("R7 maskable blocked", irq_out, 0);
        ack(v, vc); chk("R7 nmi vector", vc, 8'h02);
        chk("R7 nmi dropped", nmi_out, 0);
        wr(2'd0, 8'h00);
        ack(v, vc); chk("R3 held line0 delivered", vc, 8'h20);

        // R9 strobe during answer ignored
        pulse(0); pulse(1);
        ack_stb = 1; tick();
        chk("R9 first answer", vec_out, 8'h20);
        tick(); ack_stb = 0;
        chk("R9 second strobe ignored", vec_valid, 0);
        rd(2'd1, r); chk("R9 line1 still pending", r, 8'h02);
        ack(v, vc); chk("R9 line1 later", vc, 8'h21);

        // R11 edge at the same edge as its clear
        pulse(2);
        dev_req[2] = 1; ack_stb = 1; tick(); ack_stb = 0; dev_req[2] = 0;
        chk("R11 vector line3", vec_out, 8'h23);
        rd(2'd1, r); chk("R11 pending kept", r, 8'h08);
        ack(v, vc); chk("R11 re-delivered", vc, 8'h23);

        // R10 status writes ignored
        wr(2'd3, 8'hFF); rd(2'd3, r); chk("R10 sec status write ignored", r, 8'h00);
        wr(2'd1, 8'hFF); rd(2'd1, r); chk("R10 pri status write ignored", r, 8'h00);
        rd(2'd0, r); chk("R10 mask untouched", r, 8'h00);

        // random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            dev_req  = 15'($urandom) & 15'($urandom);
            nmi_req  = ($urandom_range(0, 15) == 0);
            ack_stb  = ($urandom_range(0, 3) == 0);
            reg_addr = 2'($urandom);
            reg_we   = ($urandom_range(0, 9) == 0);
            reg_wdata = 8'($urandom) & 8'($urandom);
            tick();
        end
        dev_req = '0; nmi_req = 0; ack_stb = 0; reg_we = 0;
        repeat (4) tick();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule